// File: doc/BRIEF.md
# Bus Receiver Conditioning Controller

This block produces the gating enables for the input receivers of an I/O attachment on a shared bidirectional bus. A receiver that is not gated on draws less current from the bus, so more attachments can share one line. The controller decides, one clock at a time, which receiver groups of this attachment should listen. The high address byte, the low address byte and the data bus each have their own enable.

All bus inputs are sampled into a register stage first. The two address enables are decoded from that stage with no memory, so they follow the select bit and the device match with one cycle of latency. The data enable has memory. It is armed by either of two unrelated events: a programmed selection of this device that has address bit 1 set, or a cycle-steal service capture for an output transfer. Each event keeps its own flag. A flag holds until the falling edge of its own return handshake clears it. The data enable is the OR of the two flags.

Top module: `rcv_cond_ctrl`

## Requirements
- R1: `en_addr_hi` equals bit 16 of `addr_bus` as sampled at the previous clock edge.
- R2: `en_addr_lo` is high one cycle after an edge at which `addr_bus[16]` and `dev_match` were both 1. At all other times it is low.
- R3: A programmed selection samples `addr_bus[16]`, `dev_match` and `addr_bus[1]` all at 1. It drives `en_data` high two edges after that sampling. A selection with `addr_bus[1]` at 0 does not arm it.
- R4: After R3 arms the data enable, it stays high while the selection is withdrawn. It clears two edges after `addr_gate_ret` is first sampled 0, having been sampled 1 on the edge before.
- R5: A one-cycle `cs_capture` with `cs_out_xfer` at 1 drives `en_data` high two edges later. It stays high until two edges after `svc_gate_ret` is first sampled 0, following a 1.
- R6: A `cs_capture` with `cs_out_xfer` at 0 (an input transfer) leaves `en_data` low.
- R7: `en_data` is high while either flag is set. Clearing one flag does not drop it while the other flag is set.
- R8: If a falling return edge and a new arming event are sampled on the same edge, that flag stays clear. It arms only on a later event.
- R9: `rst_n` sampled low forces all three enables to 0 after that edge. The reset is synchronous.
- R10: The address enables do not hold. Each falls one edge after its qualifying inputs go away.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_bus | input | 17 | Address bus; bit 16 is the select bit, bit 1 qualifies data conditioning |
| dev_match | input | 1 | The device address comparison matched |
| addr_gate_ret | input | 1 | Address gate return handshake |
| svc_gate_ret | input | 1 | Service gate return handshake |
| cs_capture | input | 1 | Service gate capture for a cycle-steal sequence |
| cs_out_xfer | input | 1 | The cycle-steal sequence is an output transfer |
| en_addr_hi | output | 1 | Enable for address bits 8-15 receivers |
| en_addr_lo | output | 1 | Enable for address bits 0-7 receivers |
| en_data | output | 1 | Enable for data bus receivers |

## Verification
The bench arms the data enable from each source on its own and then from both together. It drops one return while the other flag still holds, which catches a design that clears both flags on any return edge. It samples a falling return on the same edge as a new selection. A design that lets the arming win there leaves the data enable stuck high. It raises a capture with the input direction, and a design that skipped the direction check would enable the data receivers. It also asserts reset while a flag is set, and withdraws the selection while a flag holds, so address enables that wrongly latched would show up there.

// File: rtl/rcvc_pkg.sv
// Package: shared defaults and the sampled-control record for the
// receiver conditioning controller. Assumes a 17-bit address bus.
package rcvc_pkg;
    parameter int unsigned RC_ADDR_W  = 17;
    parameter int unsigned RC_SEL_BIT = 16;
    parameter int unsigned RC_DAT_BIT = 1;
    parameter int unsigned RC_NSRC    = 2;

    // One registered snapshot of the bus control conditions.
    typedef struct packed {
        logic sel;
        logic match;
        logic dbit;
        logic agr;
        logic sgr;
        logic cap;
        logic outx;
    } rc_ctl_t;
endpackage

// File: rtl/rcvc_sample.sv
// Input stage: registers the bus control conditions once per clock and
// keeps the previous value of both return handshakes for edge finding.
// Assumes inputs are synchronous to clk.
module rcvc_sample
    import rcvc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  rc_ctl_t ctl_in,
    output rc_ctl_t ctl_q,
    output logic    agr_prev,
    output logic    sgr_prev
);
    // Capture the current conditions and the prior handshake levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            agr_prev <= 1'b0;
            sgr_prev <= 1'b0;
        end else begin
            ctl_q    <= ctl_in;
            agr_prev <= ctl_q.agr;
            sgr_prev <= ctl_q.sgr;
        end
    end
endmodule

// File: rtl/rcvc_flag.sv
// Set/clear hold flag for one data conditioning source. Clear takes
// priority over set. Assumes set and clr come from registered logic.
module rcvc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold the flag between its arming event and its clearing edge.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (clr) q <= 1'b0;
        else if (set) q <= 1'b1;
    end
endmodule

// File: rtl/rcv_cond_ctrl.sv
// Top: receiver conditioning controller. Decodes the address enables
// from the sampled bus, and holds the data enable from either of two
// sources until the matching return handshake falls.
// Assumes one clock domain with a synchronous active-low reset.
module rcv_cond_ctrl
    import rcvc_pkg::*;
#(
    parameter int unsigned ADDR_W  = RC_ADDR_W,
    parameter int unsigned SEL_BIT = RC_SEL_BIT,
    parameter int unsigned DAT_BIT = RC_DAT_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_bus,
    input  logic              dev_match,
    input  logic              addr_gate_ret,
    input  logic              svc_gate_ret,
    input  logic              cs_capture,
    input  logic              cs_out_xfer,
    output logic              en_addr_hi,
    output logic              en_addr_lo,
    output logic              en_data
);
    localparam int unsigned NSRC = RC_NSRC;
    localparam int unsigned SRC_PGM = 0;
    localparam int unsigned SRC_CS  = 1;

    rc_ctl_t          ctl_in;
    rc_ctl_t          ctl_q;
    logic             agr_prev;
    logic             sgr_prev;
    logic [NSRC-1:0]  arm;
    logic [NSRC-1:0]  drop;
    logic [NSRC-1:0]  held;

    // Gather the raw bus conditions into one record.
    always_comb begin
        ctl_in.sel   = addr_bus[SEL_BIT];
        ctl_in.match = dev_match;
        ctl_in.dbit  = addr_bus[DAT_BIT];
        ctl_in.agr   = addr_gate_ret;
        ctl_in.sgr   = svc_gate_ret;
        ctl_in.cap   = cs_capture;
        ctl_in.outx  = cs_out_xfer;
    end

    rcvc_sample u_sample (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_in   (ctl_in),
        .ctl_q    (ctl_q),
        .agr_prev (agr_prev),
        .sgr_prev (sgr_prev)
    );

    // Address enables decoded straight from the sampled conditions.
    always_comb begin
        en_addr_hi = ctl_q.sel;
        en_addr_lo = ctl_q.sel & ctl_q.match;
    end

    // Arming events and falling return edges for each data source.
    always_comb begin
        arm[SRC_PGM]  = ctl_q.sel & ctl_q.match & ctl_q.dbit;
        arm[SRC_CS]   = ctl_q.cap & ctl_q.outx;
        drop[SRC_PGM] = agr_prev & ~ctl_q.agr;
        drop[SRC_CS]  = sgr_prev & ~ctl_q.sgr;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        rcvc_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (arm[g]),
            .clr   (drop[g]),
            .q     (held[g])
        );
    end

    // Data enable is live while any source flag holds.
    always_comb en_data = |held;
endmodule

// File: rtl/rcvc_chk.sv
// Checker: port-level timing properties of the conditioning controller.
// Assumes the default bit positions of the top module.
module rcvc_chk #(
    parameter int unsigned ADDR_W  = 17,
    parameter int unsigned SEL_BIT = 16,
    parameter int unsigned DAT_BIT = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_bus,
    input logic              dev_match,
    input logic              addr_gate_ret,
    input logic              svc_gate_ret,
    input logic              cs_capture,
    input logic              cs_out_xfer,
    input logic              en_addr_hi,
    input logic              en_addr_lo,
    input logic              en_data
);
    logic [1:0] live;

    // Count clock edges since reset was released, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)          live <= 2'd0;
        else if (live != 2'd3) live <= live + 2'd1;
    end

    AST_HI_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (live >= 2'd1) |-> (en_addr_hi == $past(addr_bus[SEL_BIT]))); // R1
    AST_LO_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (live >= 2'd1) |-> (en_addr_lo == ($past(addr_bus[SEL_BIT]) && $past(dev_match)))); // R2
    AST_DATA_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((live >= 2'd2) && $rose(en_data)) |->
        (($past(addr_bus[SEL_BIT], 2) && $past(dev_match, 2) && $past(addr_bus[DAT_BIT], 2))
         || ($past(cs_capture, 2) && $past(cs_out_xfer, 2)))); // R6
    AST_DATA_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((live == 2'd3) && $fell(en_data)) |->
        (($past(addr_gate_ret, 3) && !$past(addr_gate_ret, 2))
         || ($past(svc_gate_ret, 3) && !$past(svc_gate_ret, 2)))); // R4
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!en_addr_hi && !en_addr_lo && !en_data)); // R9
endmodule

bind rcv_cond_ctrl rcvc_chk #(
    .ADDR_W  (ADDR_W),
    .SEL_BIT (SEL_BIT),
    .DAT_BIT (DAT_BIT)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr_bus      (addr_bus),
    .dev_match     (dev_match),
    .addr_gate_ret (addr_gate_ret),
    .svc_gate_ret  (svc_gate_ret),
    .cs_capture    (cs_capture),
    .cs_out_xfer   (cs_out_xfer),
    .en_addr_hi    (en_addr_hi),
    .en_addr_lo    (en_addr_lo),
    .en_data       (en_data)
);

// File: tb/rcv_cond_ctrl_tb_top.sv
// Scoreboard bench: the driver queues expected enables with a due cycle,
// and the monitor compares them just after each clock edge.
module rcv_cond_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] addr_bus = '0;
    logic        dev_match = 1'b0;
    logic        addr_gate_ret = 1'b0;
    logic        svc_gate_ret = 1'b0;
    logic        cs_capture = 1'b0;
    logic        cs_out_xfer = 1'b0;
    logic        en_addr_hi, en_addr_lo, en_data;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        int         due;
        logic [2:0] mask;
        logic [2:0] val;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    rcv_cond_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_bus      (addr_bus),
        .dev_match     (dev_match),
        .addr_gate_ret (addr_gate_ret),
        .svc_gate_ret  (svc_gate_ret),
        .cs_capture    (cs_capture),
        .cs_out_xfer   (cs_out_xfer),
        .en_addr_hi    (en_addr_hi),
        .en_addr_lo    (en_addr_lo),
        .en_data       (en_data)
    );

    // Monitor: count edges, then compare every item that has come due.
    always begin
        @(posedge clk);
        cyc++;
        #1;
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due <= cyc) begin
                logic [2:0] act;
                act = {en_addr_hi, en_addr_lo, en_data};
                total++;
                if (sb[i].due < cyc || ((act & sb[i].mask) != (sb[i].val & sb[i].mask))) begin
                    bad++;
                    $display("FAIL %s: hi/lo/data actual=%b expected=%b mask=%b cyc=%0d",
                             sb[i].tag, act, sb[i].val, sb[i].mask, cyc);
                end
                sb.delete(i);
            end
        end
    end

    // Queue an expectation lat edges after the current negedge.
    task automatic expect_at(input int lat, input logic [2:0] mask,
                             input logic [2:0] val, input string tag);
        exp_t e;
        e.due = cyc + lat; e.mask = mask; e.val = val; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pgm_sel(input logic sel, input logic m, input logic b1);
        addr_bus = '0;
        addr_bus[16] = sel;
        addr_bus[1]  = b1;
        addr_bus[9]  = 1'b1;
        dev_match = m;
    endtask

    initial begin
        tick(1);
        tick(3);
        rst_n = 1'b1;
        expect_at(1, 3'b111, 3'b000, "R9 reset state");
        tick(2);

        // R1/R2: select without match, then with match but bit 1 clear.
        pgm_sel(1, 0, 0);
        expect_at(1, 3'b110, 3'b100, "R1 R2 select no match");
        tick(1);
        pgm_sel(1, 1, 0);
        expect_at(1, 3'b110, 3'b110, "R2 select with match");
        expect_at(2, 3'b001, 3'b000, "R3 bit1 clear no arm");
        tick(1);
        pgm_sel(0, 1, 0);
        expect_at(1, 3'b110, 3'b000, "R10 address enables drop");
        tick(3);

        // R3/R4: program selection with bit 1, hold until address return falls.
        addr_gate_ret = 1'b1;
        tick(1);
        pgm_sel(1, 1, 1);
        expect_at(2, 3'b001, 3'b001, "R3 program arm");
        tick(1);
        pgm_sel(0, 0, 0);
        expect_at(1, 3'b110, 3'b000, "R10 selection withdrawn");
        expect_at(3, 3'b001, 3'b001, "R4 held after withdraw");
        tick(4);
        addr_gate_ret = 1'b0;
        expect_at(1, 3'b001, 3'b001, "R4 still held one edge");
        expect_at(2, 3'b001, 3'b000, "R4 cleared on return fall");
        tick(4);

        // R5: cycle-steal output capture, held until service return falls.
        svc_gate_ret = 1'b1;
        cs_out_xfer = 1'b1;
        cs_capture = 1'b1;
        expect_at(2, 3'b001, 3'b001, "R5 cs output arm");
        tick(1);
        cs_capture = 1'b0;
        expect_at(4, 3'b001, 3'b001, "R5 cs held");
        tick(4);
        svc_gate_ret = 1'b0;
        expect_at(2, 3'b001, 3'b000, "R5 cleared on service fall");
        tick(4);

        // R6: input transfer capture must not arm.
        svc_gate_ret = 1'b1;
        cs_out_xfer = 1'b0;
        cs_capture = 1'b1;
        expect_at(2, 3'b001, 3'b000, "R6 input capture ignored");
        tick(1);
        cs_capture = 1'b0;
        expect_at(3, 3'b001, 3'b000, "R6 still low");
        tick(4);

        // R7: both flags set; drop one return, then the other.
        addr_gate_ret = 1'b1;
        tick(1);
        pgm_sel(1, 1, 1);
        cs_out_xfer = 1'b1;
        cs_capture = 1'b1;
        tick(1);
        pgm_sel(0, 0, 0);
        cs_capture = 1'b0;
        tick(3);
        addr_gate_ret = 1'b0;
        expect_at(2, 3'b001, 3'b001, "R7 other flag keeps data");
        expect_at(4, 3'b001, 3'b001, "R7 still held");
        tick(5);
        svc_gate_ret = 1'b0;
        expect_at(2, 3'b001, 3'b000, "R7 both cleared");
        tick(4);

        // R8: return falls on the same edge as a new arming event.
        addr_gate_ret = 1'b1;
        tick(1);
        addr_gate_ret = 1'b0;
        pgm_sel(1, 1, 1);
        expect_at(2, 3'b001, 3'b000, "R8 clear wins");
        tick(1);
        pgm_sel(0, 0, 0);
        expect_at(2, 3'b001, 3'b000, "R8 no late arm");
        tick(4);
        pgm_sel(1, 1, 1);
        expect_at(2, 3'b001, 3'b001, "R8 later event re-arms");
        tick(1);
        pgm_sel(0, 0, 0);
        tick(3);

        // R9: reset in the middle of a held flag.
        rst_n = 1'b0;
        expect_at(1, 3'b111, 3'b000, "R9 reset clears hold");
        tick(1);
        rst_n = 1'b1;
        expect_at(3, 3'b001, 3'b000, "R9 stays clear");
        tick(5);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #(4 * 20000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule